// File: doc/BRIEF.md
# Interleaved Pairwise Lane XOR Unit

This SIMD execution unit pairs each lane of a first source vector with the neighbouring lane of a second source vector and XORs them. Lanes are grouped into pairs (2k, 2k+1), and within a pair the partner lane is the other member of that pair. Only one parity of destination lanes receives a result. In the bottom-top variant the even lanes are written. In the top-bottom variant the odd lanes are written. Every lane of the other parity passes the previous destination value through unchanged. The lane width can be 8, 16, 32 or 64 bits. The vector width is a parameter that must be a multiple of 128 bits, from 128 to 2048.

The datapath has one register stage. A request is presented with `in_valid`. The merged vector appears on `dst_out` one cycle later, together with `out_valid`, and it stays there until the next request. Alongside the datapath, a combinational decoder examines a 32-bit instruction word. It reports whether the word belongs to this operation and extracts the element size, the variant and the three register numbers. The register file is not part of the block. When a source register is also the destination, the caller presents the same data on both ports. The result is built from the values present at the capturing edge.

Top module: `ilx_unit`

## Requirements
- R1: With `odd_sel`=0 (bottom-top), every even lane 2k of `dst_out` equals `src_a` lane 2k XOR `src_b` lane 2k+1.
- R2: With `odd_sel`=1 (top-bottom), every odd lane 2k+1 of `dst_out` equals `src_a` lane 2k+1 XOR `src_b` lane 2k.
- R3: Lanes of the parity that is not written take the value of the corresponding lane of `dst_old`.
- R4: `esize` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane 0 occupies the least significant bits.
- R5: `out_valid` is `in_valid` delayed by exactly one clock cycle, and the result of a request appears in the same cycle as its `out_valid`.
- R6: While `in_valid` is low, `dst_out` holds its last value, whatever the data inputs do.
- R7: A synchronous active-high `rst` clears `out_valid` and sets `dst_out` to zero.
- R8: `dec_hit` is 1 exactly when (`insn_word` AND 0xFF20F800) equals 0x45009000. Bits 21 and 14 are part of the fixed pattern.
- R9: The decoder reports the element size from bits 23:22, the variant from bit 10 (0 = bottom-top, 1 = top-bottom), the destination register from bits 4:0, the first source from bits 9:5 and the second source from bits 20:16.
- R10: When the same vector is presented as a source and as the old destination (register aliasing), the result is computed from the values presented in the request cycle.
- R11: The behaviour is identical for any `VLEN` of 128·n. It is exercised at 128 and 256 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| esize | input | 2 | Lane width code |
| odd_sel | input | 1 | Variant: 0 writes even lanes, 1 writes odd lanes |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector (partner lanes) |
| dst_old | input | VLEN | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| dst_out | output | VLEN | Merged destination vector |
| insn_word | input | 32 | Instruction word to decode |
| dec_hit | output | 1 | Instruction word matches this operation |
| dec_esize | output | 2 | Decoded lane width code |
| dec_odd | output | 1 | Decoded variant |
| dec_rd | output | 5 | Decoded destination register |
| dec_rn | output | 5 | Decoded first source register |
| dec_rm | output | 5 | Decoded second source register |

## Verification
Every combination of lane width and variant is driven at 128 and 256 bits with several operand patterns. An all-ones first source against a zero second source shows which lanes are written. A walking-one pattern in the second source shows that each written lane takes its partner lane and not its own. Random vectors catch any crossed bit positions. Aliased requests, in which the first source equals the old destination, confirm that the kept lanes and the computed lanes both use the presented values. Decoder words are swept over all sizes and variants, and words with a single fixed bit flipped show that non-matching encodings are rejected.

// File: rtl/ilx_pkg.sv
package ilx_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  localparam logic [31:0] OPC_MASK  = 32'hFF20_F800;
  localparam logic [31:0] OPC_MATCH = 32'h4500_9000;

  typedef struct packed {
    logic       hit;
    esize_e     size;
    logic       odd;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } dec_fields_t;
endpackage

// File: rtl/ilx_decode.sv
module ilx_decode
  import ilx_pkg::*;
(
  input  logic [31:0] insn,
  output dec_fields_t fields
);
  always_comb begin
    fields.hit  = ((insn & OPC_MASK) == OPC_MATCH);
    fields.size = esize_e'(insn[23:22]);
    fields.odd  = insn[10];
    fields.rd   = insn[4:0];
    fields.rn   = insn[9:5];
    fields.rm   = insn[20:16];
  end

  // R8: a hit always carries the fixed opcode byte
  always_comb begin
    if (fields.hit) assert_hit_opcode_R8: assert (insn[31:24] == 8'h45);
  end
endmodule

// File: rtl/ilx_lane_xor.sv
module ilx_lane_xor
  import ilx_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] a,
  input  logic [VLEN-1:0] b,
  input  logic [VLEN-1:0] old,
  input  esize_e          size,
  input  logic            odd,
  output logic [VLEN-1:0] res
);
  localparam int NSIZE = 4;

  logic [VLEN-1:0] cand [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int W = 8 << s;
    logic [VLEN-1:0] v;
    for (genvar i = 0; i < VLEN; i++) begin : g_bit
      if (((i / W) % 2) == 1) begin : g_odd_lane
        assign v[i] = odd ? (a[i] ^ b[i-W]) : old[i];
      end else begin : g_even_lane
        assign v[i] = odd ? old[i] : (a[i] ^ b[i+W]);
      end
    end
    assign cand[s] = v;
  end

  always_comb begin
    unique case (size)
      ESZ_8:   res = cand[0];
      ESZ_16:  res = cand[1];
      ESZ_32:  res = cand[2];
      default: res = cand[3];
    endcase
  end
endmodule

// File: rtl/ilx_unit.sv
module ilx_unit
  import ilx_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      esize,
  input  logic            odd_sel,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] dst_old,
  output logic            out_valid,
  output logic [VLEN-1:0] dst_out,
  input  logic [31:0]     insn_word,
  output logic            dec_hit,
  output logic [1:0]      dec_esize,
  output logic            dec_odd,
  output logic [4:0]      dec_rd,
  output logic [4:0]      dec_rn,
  output logic [4:0]      dec_rm
);
  localparam int NBYTE = VLEN / 8;

  dec_fields_t     dfields;
  logic [VLEN-1:0] merged;
  logic [VLEN-1:0] dst_q;
  logic            vld_q;

  ilx_decode u_dec (
    .insn   (insn_word),
    .fields (dfields)
  );

  assign dec_hit   = dfields.hit;
  assign dec_esize = dfields.size;
  assign dec_odd   = dfields.odd;
  assign dec_rd    = dfields.rd;
  assign dec_rn    = dfields.rn;
  assign dec_rm    = dfields.rm;

  ilx_lane_xor #(.VLEN(VLEN)) u_xor (
    .a    (src_a),
    .b    (src_b),
    .old  (dst_old),
    .size (esize_e'(esize)),
    .odd  (odd_sel),
    .res  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dst_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) dst_q <= merged;
    end
  end

  assign out_valid = vld_q;
  assign dst_out   = dst_q;

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && dst_out == '0));

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst_out));

  for (genvar j = 0; j < NBYTE; j++) begin : g_keep_chk
    assert_keep_lane_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(esize) == 2'd0 &&
       $past(odd_sel) != (j % 2 == 1))
      |-> dst_out[j*8 +: 8] == $past(dst_old[j*8 +: 8]));
  end
endmodule

// File: tb/tb_ilx_unit.sv
module tb_ilx_unit;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    esize = 2'd0;
  logic          odd_sel = 1'b0;
  logic [VW-1:0] a = '0, b = '0, old = '0;
  logic [31:0]   insn = 32'd0;

  logic          ov1, ov2;
  logic [127:0]  d1;
  logic [VW-1:0] d2;
  logic          hit1, hit2, odd1, odd2;
  logic [1:0]    sz1, sz2;
  logic [4:0]    rd1, rn1, rm1, rd2, rn2, rm2;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ilx_unit #(.VLEN(128)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize), .odd_sel(odd_sel),
    .src_a(a[127:0]), .src_b(b[127:0]), .dst_old(old[127:0]),
    .out_valid(ov1), .dst_out(d1), .insn_word(insn),
    .dec_hit(hit1), .dec_esize(sz1), .dec_odd(odd1),
    .dec_rd(rd1), .dec_rn(rn1), .dec_rm(rm1));

  ilx_unit #(.VLEN(VW)) dut2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize), .odd_sel(odd_sel),
    .src_a(a), .src_b(b), .dst_old(old),
    .out_valid(ov2), .dst_out(d2), .insn_word(insn),
    .dec_hit(hit2), .dec_esize(sz2), .dec_odd(odd2),
    .dec_rd(rd2), .dec_rn(rn2), .dec_rm(rm2));

  task automatic chk(input bit ok, input string req,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] model(input logic [VW-1:0] sa, input logic [VW-1:0] sb,
                                          input logic [VW-1:0] so, input int sz,
                                          input bit od, input int vl);
    logic [VW-1:0] r;
    int w = 8 << sz;
    r = so;
    for (int lane = 0; lane < vl / w; lane++) begin
      if ((lane % 2) == int'(od)) begin
        int partner = od ? lane - 1 : lane + 1;
        for (int k = 0; k < w; k++)
          r[lane*w + k] = sa[lane*w + k] ^ sb[partner*w + k];
      end
    end
    for (int k = vl; k < VW; k++) r[k] = 1'b0;
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic request(input int sz, input bit od, input string req);
    logic [VW-1:0] e1, e2;
    @(negedge clk);
    esize = 2'(sz); odd_sel = od; in_valid = 1'b1;
    e1 = model(a, b, old, sz, od, 128);
    e2 = model(a, b, old, sz, od, VW);
    @(negedge clk);
    in_valid = 1'b0;
    chk(ov1 && ov2, "R5 out_valid one cycle after request", {ov1, ov2}, 2'b11);
    chk(d1 == e1[127:0], {req, " VLEN=128"}, d1, e1);
    chk(d2 == e2, {req, " VLEN=256 R11"}, d2, e2);
  endtask

  task automatic dec_check(input int sz, input bit od, input int rd, input int rn, input int rm);
    insn = 32'h4500_9000 | (32'(sz) << 22) | (32'(rm) << 16) | (32'(od) << 10)
         | (32'(rn) << 5) | 32'(rd);
    #1;
    chk(hit1 && hit2, "R8 matching word", hit1, 1);
    chk(sz1 == 2'(sz) && odd1 == od && rd1 == 5'(rd) && rn1 == 5'(rn) && rm1 == 5'(rm),
        "R9 decoded fields", {sz1, odd1, rd1, rn1, rm1},
        {2'(sz), od, 5'(rd), 5'(rn), 5'(rm)});
    insn = insn ^ 32'h0020_0000;
    #1;
    chk(!hit1, "R8 bit 21 flipped rejected", hit1, 0);
    insn = insn ^ 32'h0020_4000;
    #1;
    chk(!hit1, "R8 bit 14 flipped rejected", hit1, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ov1 && !ov2 && d1 == '0 && d2 == '0, "R7 reset state", {ov1, ov2, d2}, '0);

    for (int sz = 0; sz < 4; sz++) begin
      for (int od = 0; od < 2; od++) begin
        a = '1; b = '0; old = '0;
        request(sz, od[0], od ? "R2 R3 R4 ones/zero" : "R1 R3 R4 ones/zero");
        a = '0; old = {VW/8{8'hA5}};
        for (int p = 0; p < 8; p++) begin
          b = '0; b[p * 29 % VW] = 1'b1;
          request(sz, od[0], od ? "R2 R4 walking one" : "R1 R4 walking one");
        end
        for (int p = 0; p < 4; p++) begin
          a = rnd(); b = rnd(); old = rnd();
          request(sz, od[0], od ? "R2 R3 random" : "R1 R3 random");
        end
        a = rnd(); b = rnd(); old = a;
        request(sz, od[0], "R10 first source aliases destination");
        b = old;
        request(sz, od[0], "R10 both sources alias destination");
      end
    end

    held = d2;
    a = rnd(); b = rnd(); old = rnd(); esize = 2'd1;
    repeat (3) @(negedge clk);
    chk(d2 == held, "R6 output held while idle", d2, held);
    chk(!ov2, "R5 out_valid low while idle", ov2, 0);

    a = rnd(); b = rnd();
    @(negedge clk); in_valid = 1'b1; rst = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b0;
    chk(!ov1 && !ov2 && d2 == '0, "R7 reset overrides request", {ov2, d2}, '0);

    for (int sz = 0; sz < 4; sz++)
      for (int od = 0; od < 2; od++)
        dec_check(sz, od[0], sz * 7 + od, 31 - sz, sz * 5 + 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule